// File: doc/BRIEF.md
# AC-Link Frame Sync Supervisor

This block watches the SYNC line of a serial audio link, sampled on every rising edge of the bit clock, and checks that each 256-bit frame is framed correctly. A frame begins with SYNC high for exactly 16 bit clocks, and the next frame must begin exactly 256 bit clocks after the previous one. Any deviation from these rules is a framing violation. On a violation the block declares loss of synchronisation.

While synchronisation is lost, the block mutes every analog output and drives the codec-ready indication low. It also blocks register reads and writes and stops the transmission of capture samples. All four controls are released together, and only after two valid frames in a row. The block also provides a frame-start pulse, the bit position in the frame, and the slot number and bit-within-slot of the last sampled bit. Downstream serialisers use these to align slot data. Decoding the slot contents is not part of this block.

Top module: `aclink_sync_monitor`

## Requirements
- R1: While reset is held and after it is released, with no SYNC seen yet, sync_lost=1, mute_all=1, codec_ready_ok=0, reg_access_enable=0, capture_enable=0 and frame_start=0.
- R2: The first rising SYNC sampled after reset, or after a violation, anchors a new frame at position 0 and is not checked against any earlier frame.
- R3: bit_pos gives the position of the last sampled bit, 0 to 255. Slot 0 covers positions 0 to 15. Slots 1 to 12 each cover 20 positions. So position 15 is slot 0 bit 15, position 16 is slot 1 bit 0, position 36 is slot 2 bit 0, and position 255 is slot 12 bit 19.
- R4: SYNC sampled low at any position 1 to 15 of a frame is a violation. sync_lost is 1 in the cycle after that sample.
- R5: SYNC sampled high at position 16 (a 17th high bit) is a violation. It is flagged in the cycle after that sample.
- R6: A rising SYNC sampled at any position other than the 256th period after the previous frame start is a violation. An example is a rise at position 255, which gives a period of 255.
- R7: If SYNC is sampled low where the 256th period falls, that is a violation (a missing start). bit_pos then wraps to 0.
- R8: In the cycle after a violation, mute_all=1 and codec_ready_ok, reg_access_enable and capture_enable are all 0.
- R9: Loss is cleared in the cycle after the rising SYNC that completes the second consecutive valid frame. It is not cleared after only one valid frame.
- R10: A violation during recovery sets the valid-frame count back to zero, so two further valid frames are needed.
- R11: frame_start is 1 in the cycle after any sampled rising SYNC, and bit_pos is 0 in that cycle, including after an early rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; SYNC is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Frame synchronisation line from the controller |
| frame_start | output | 1 | One-cycle pulse after a sampled rising SYNC |
| bit_pos | output | 8 | Position in the frame of the last sampled bit |
| slot_num | output | 4 | Slot holding the last sampled bit |
| slot_bit | output | 5 | Bit index within that slot |
| sync_lost | output | 1 | High while synchronisation is lost |
| mute_all | output | 1 | Mute request for every analog output |
| codec_ready_ok | output | 1 | Permission to report codec ready in outgoing frames |
| reg_access_enable | output | 1 | Register reads and writes are honoured when high |
| capture_enable | output | 1 | Capture sample transmission is allowed when high |

## Verification
Every result is registered once from the SYNC sample that causes it. A violation, a frame-start pulse, a counter step or a recovery therefore appears in the cycle right after the bit clock edge that sampled the offending or completing SYNC value. The bench changes SYNC shortly after each rising edge and reads the outputs after the next rising edge. Each check therefore names the exact frame position of the stimulus that produced it. Each check is placed one sample before and one sample after the boundary it tests, for SYNC widths of 15, 16 and 17 and periods of 255, 256 and 257. This shows that neither the flag nor the recovery arrives a cycle early or late.

// File: rtl/aclink_sync_monitor.sv
module aclink_sync_monitor #(
  parameter int FRAME_BITS  = 256,
  parameter int SYNC_BITS   = 16,
  parameter int TAG_BITS    = 16,
  parameter int SLOT_BITS   = 20,
  parameter int GOOD_FRAMES = 2,
  localparam int PW = $clog2(FRAME_BITS),
  localparam int NSLOTS = 1 + (FRAME_BITS - TAG_BITS) / SLOT_BITS,
  localparam int SW = $clog2(NSLOTS),
  localparam int BW = $clog2(SLOT_BITS)
) (
  input  logic          bit_clk,
  input  logic          rst_n,
  input  logic          sync,
  output logic          frame_start,
  output logic [PW-1:0] bit_pos,
  output logic [SW-1:0] slot_num,
  output logic [BW-1:0] slot_bit,
  output logic          sync_lost,
  output logic          mute_all,
  output logic          codec_ready_ok,
  output logic          reg_access_enable,
  output logic          capture_enable
);

  localparam int GW = $clog2(GOOD_FRAMES + 1);
  localparam logic [PW-1:0] LAST_POS = PW'(FRAME_BITS - 1);

  logic          sync_q, armed, lost;
  logic [GW-1:0] good;
  logic [PW-1:0] seq;
  logic          rise, at_end, v_short, v_long, v_early, v_miss, viol, good_end, slot_wrap;

  assign rise     = sync & ~sync_q;
  assign at_end   = (bit_pos == LAST_POS);
  assign seq      = at_end ? '0 : bit_pos + 1'b1;

  assign v_short  = armed && !rise && seq != '0 && seq < PW'(SYNC_BITS) && !sync;
  assign v_long   = armed && !rise && seq == PW'(SYNC_BITS) && sync;
  assign v_early  = armed && rise && !at_end;
  assign v_miss   = armed && at_end && !rise;
  assign viol     = v_short | v_long | v_early | v_miss;
  assign good_end = armed && rise && at_end;

  assign slot_wrap = (slot_num == '0) ? (slot_bit == BW'(TAG_BITS - 1))
                                      : (slot_bit == BW'(SLOT_BITS - 1));

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q      <= 1'b0;
      frame_start <= 1'b0;
      bit_pos     <= '0;
      slot_num    <= '0;
      slot_bit    <= '0;
    end else begin
      sync_q      <= sync;
      frame_start <= rise;
      bit_pos     <= rise ? '0 : seq;
      if (rise || seq == '0) begin
        slot_num <= '0;
        slot_bit <= '0;
      end else if (slot_wrap) begin
        slot_num <= slot_num + 1'b1;
        slot_bit <= '0;
      end else begin
        slot_bit <= slot_bit + 1'b1;
      end
    end
  end

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      lost  <= 1'b1;
      good  <= '0;
    end else begin
      if (rise)      armed <= 1'b1;
      else if (viol) armed <= 1'b0;
      if (viol) begin
        lost <= 1'b1;
        good <= '0;
      end else if (good_end && lost) begin
        if (good == GW'(GOOD_FRAMES - 1)) begin
          lost <= 1'b0;
          good <= '0;
        end else begin
          good <= good + 1'b1;
        end
      end
    end
  end

  assign sync_lost         = lost;
  assign mute_all          = lost;
  assign codec_ready_ok    = ~lost;
  assign reg_access_enable = ~lost;
  assign capture_enable    = ~lost;

endmodule

// File: rtl/aclink_sync_monitor_chk.sv
module aclink_sync_monitor_chk #(
  parameter int FRAME_BITS = 256,
  parameter int SYNC_BITS  = 16,
  parameter int TAG_BITS   = 16,
  parameter int SLOT_BITS  = 20,
  localparam int PW = $clog2(FRAME_BITS),
  localparam int NSLOTS = 1 + (FRAME_BITS - TAG_BITS) / SLOT_BITS,
  localparam int SW = $clog2(NSLOTS),
  localparam int BW = $clog2(SLOT_BITS)
) (
  input logic          bit_clk,
  input logic          rst_n,
  input logic          sync,
  input logic          frame_start,
  input logic [PW-1:0] bit_pos,
  input logic [SW-1:0] slot_num,
  input logic [BW-1:0] slot_bit,
  input logic          sync_lost
);

  a_r4_short_sync: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (!sync_lost && bit_pos < PW'(SYNC_BITS - 1) && !sync) |=> sync_lost);

  a_r5_long_sync: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (!sync_lost && bit_pos == PW'(SYNC_BITS - 1) && sync) |=> sync_lost);

  a_r6_early_rise: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (!sync_lost && bit_pos >= PW'(SYNC_BITS) && bit_pos != PW'(FRAME_BITS - 1) && sync)
      |=> sync_lost);

  a_r7_missing_start: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (!sync_lost && bit_pos == PW'(FRAME_BITS - 1) && !sync) |=> sync_lost);

  a_r9_clear_on_start: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $fell(sync_lost) |-> frame_start);

  a_r11_start_anchor: assert property (@(posedge bit_clk) disable iff (!rst_n)
    frame_start |-> (bit_pos == '0 && slot_num == '0 && slot_bit == '0));

  a_r3_slot_one: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (bit_pos == PW'(TAG_BITS)) |-> (slot_num == SW'(1) && slot_bit == '0));

endmodule

bind aclink_sync_monitor aclink_sync_monitor_chk #(
  .FRAME_BITS(FRAME_BITS), .SYNC_BITS(SYNC_BITS),
  .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS)
) u_chk (
  .bit_clk(bit_clk), .rst_n(rst_n), .sync(sync), .frame_start(frame_start),
  .bit_pos(bit_pos), .slot_num(slot_num), .slot_bit(slot_bit), .sync_lost(sync_lost)
);

// File: tb/tb_aclink_sync_monitor.sv
module tb_aclink_sync_monitor;
  logic       bit_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync = 1'b0;
  logic       frame_start, sync_lost, mute_all, codec_ready_ok, reg_access_enable, capture_enable;
  logic [7:0] bit_pos;
  logic [3:0] slot_num;
  logic [4:0] slot_bit;
  int checks = 0;
  int fails = 0;

  always #4 bit_clk = ~bit_clk;

  aclink_sync_monitor dut (
    .bit_clk(bit_clk), .rst_n(rst_n), .sync(sync), .frame_start(frame_start),
    .bit_pos(bit_pos), .slot_num(slot_num), .slot_bit(slot_bit), .sync_lost(sync_lost),
    .mute_all(mute_all), .codec_ready_ok(codec_ready_ok),
    .reg_access_enable(reg_access_enable), .capture_enable(capture_enable)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input logic v);
    sync = v;
    @(posedge bit_clk);
    #2;
  endtask

  task automatic run(input logic v, input int n);
    for (int i = 0; i < n; i++) tick(v);
  endtask

  task automatic frame(input int w, input int p);
    run(1'b1, w);
    run(1'b0, p - w);
  endtask

  task automatic chk_gates(input string req, input int lost);
    chk(req, "sync_lost", sync_lost, lost);
    chk(req, "mute_all", mute_all, lost);
    chk(req, "codec_ready_ok", codec_ready_ok, !lost);
    chk(req, "reg_access_enable", reg_access_enable, !lost);
    chk(req, "capture_enable", capture_enable, !lost);
  endtask

  task automatic resync();
    run(1'b0, 3);
    frame(16, 256);
    frame(16, 256);
    tick(1'b1);
    chk("R2", "resync lost", sync_lost, 0);
  endtask

  task automatic t_reset();
    chk_gates("R1", 1);
    chk("R1", "frame_start", frame_start, 0);
  endtask

  task automatic t_recover();
    frame(16, 256);
    tick(1'b1);
    chk("R9", "lost after one good frame", sync_lost, 1);
    run(1'b1, 15);
    run(1'b0, 240);
    chk("R9", "lost before second end", sync_lost, 1);
    tick(1'b1);
    chk_gates("R9", 0);
    chk("R11", "frame_start", frame_start, 1);
    chk("R11", "bit_pos", bit_pos, 0);
  endtask

  task automatic t_counters();
    run(1'b1, 15);
    chk("R3", "pos15 bit_pos", bit_pos, 15);
    chk("R3", "pos15 slot", slot_num, 0);
    chk("R3", "pos15 bit", slot_bit, 15);
    chk("R11", "frame_start mid-frame", frame_start, 0);
    tick(1'b0);
    chk("R3", "pos16 slot", slot_num, 1);
    chk("R3", "pos16 bit", slot_bit, 0);
    run(1'b0, 19);
    chk("R3", "pos35 slot", slot_num, 1);
    chk("R3", "pos35 bit", slot_bit, 19);
    tick(1'b0);
    chk("R3", "pos36 slot", slot_num, 2);
    chk("R3", "pos36 bit", slot_bit, 0);
    run(1'b0, 219);
    chk("R3", "pos255 bit_pos", bit_pos, 255);
    chk("R3", "pos255 slot", slot_num, 12);
    chk("R3", "pos255 bit", slot_bit, 19);
    tick(1'b1);
    chk("R7", "period 256 ok", sync_lost, 0);
    chk("R11", "frame_start", frame_start, 1);
  endtask

  task automatic t_width15();
    run(1'b1, 14);
    chk("R4", "before short edge", sync_lost, 0);
    tick(1'b0);
    chk_gates("R8", 1);
    chk("R4", "width 15 flagged", sync_lost, 1);
    resync();
  endtask

  task automatic t_width17();
    run(1'b1, 15);
    chk("R5", "width 16 ok", sync_lost, 0);
    tick(1'b1);
    chk("R5", "width 17 flagged", sync_lost, 1);
    resync();
  endtask

  task automatic t_period255();
    run(1'b1, 15);
    run(1'b0, 239);
    chk("R6", "before early rise", sync_lost, 0);
    tick(1'b1);
    chk("R6", "period 255 flagged", sync_lost, 1);
    chk("R11", "early frame_start", frame_start, 1);
    chk("R11", "early bit_pos", bit_pos, 0);
    run(1'b1, 15);
    run(1'b0, 240);
    tick(1'b1);
    chk("R9", "one good after early", sync_lost, 1);
    run(1'b1, 15);
    run(1'b0, 240);
    tick(1'b1);
    chk("R9", "two good after early", sync_lost, 0);
  endtask

  task automatic t_period257();
    run(1'b1, 15);
    run(1'b0, 240);
    chk("R7", "at pos255", sync_lost, 0);
    tick(1'b0);
    chk("R7", "period 257 flagged", sync_lost, 1);
    chk("R7", "wrap bit_pos", bit_pos, 0);
    tick(1'b1);
    chk("R2", "late rise still lost", sync_lost, 1);
    chk("R2", "late rise frame_start", frame_start, 1);
    run(1'b1, 15);
    run(1'b0, 240);
    tick(1'b1);
    chk("R9", "one good after miss", sync_lost, 1);
    run(1'b1, 15);
    run(1'b0, 240);
    tick(1'b1);
    chk("R9", "two good after miss", sync_lost, 0);
  endtask

  task automatic t_relapse();
    run(1'b1, 14);
    tick(1'b0);
    chk("R4", "first violation", sync_lost, 1);
    run(1'b0, 3);
    frame(16, 256);
    tick(1'b1);
    chk("R10", "one good frame", sync_lost, 1);
    run(1'b1, 14);
    tick(1'b0);
    chk("R10", "violation in recovery", sync_lost, 1);
    run(1'b0, 3);
    frame(16, 256);
    tick(1'b1);
    chk("R10", "count restarted", sync_lost, 1);
    run(1'b1, 15);
    run(1'b0, 240);
    tick(1'b1);
    chk("R10", "recovered after two", sync_lost, 0);
  endtask

  initial begin
    repeat (4) @(posedge bit_clk);
    #2;
    chk_gates("R1", 1);
    rst_n = 1'b1;
    run(1'b0, 3);
    t_reset();
    t_recover();
    t_counters();
    t_width15();
    t_width17();
    t_period255();
    t_period257();
    t_relapse();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule